// File: doc/BRIEF.md
# GPIO Bank Controller with Edge Interrupts

This block is a register-mapped general-purpose I/O peripheral covering a 32-pin group. Software picks the direction of each pin and changes output levels only through write-one-to-set and write-one-to-clear registers. A zero in the written word leaves the matching pin alone, so two agents can update different pins without a read-modify-write race.

Every pad level passes through a synchronizer on the block clock. The synchronized levels can be read back whatever the direction of the pin. Each pin can flag a rising edge, a falling edge, or both. The enables for each kind of edge are changed through their own set and clear registers. A flagged edge latches a status bit that software clears by writing a one to it.

The 32 status bits are split into two 16-pin banks. Each bank drives its own interrupt line, and each line is gated by one bit of a bank enable register. The bus port is a plain single-cycle write strobe with a combinational read-data path selected by the byte address.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset every pin is an input (direction register reads 0xFFFFFFFF, `pin_oe` is 0). Output data, both edge-enable sets, status and bank enables all read 0, and both interrupt lines are low.
- R2: The direction register at offset 0x10 is a plain read/write register. A 1 in bit n makes pin n an input (`pin_oe[n]`=0), and a 0 makes it an output (`pin_oe[n]`=1).
- R3: A write to offset 0x18 sets the output bits where the written word holds a 1. A write to offset 0x1C clears them. Zero bits leave those outputs unchanged. Both offsets read back the current output data, which also drives `pin_out`.
- R4: Offset 0x20 returns the synchronized pad level for every pin, whatever its direction. A level applied before clock edge k is readable after edge k+1 and not after edge k.
- R5: The rising-edge enables are set through offset 0x24 and cleared through offset 0x28. The falling-edge enables are set through 0x2C and cleared through 0x30. All use write-one semantics, and each offset reads back the enable vector it changes.
- R6: A change of a pin's synchronized level between two clock cycles sets bit n of the status register (offset 0x34) only when the enable for that direction of change is set. A change whose enable is clear sets nothing.
- R7: Writing a 1 to a status bit clears it, and zeros leave it alone. A status bit never clears without such a write. An enabled edge detected in the same cycle as the clearing write leaves the bit set.
- R8: The bank enable register at offset 0x08 uses bit 0 for the lower bank and bit 1 for the upper bank, and reads back only those two bits. `irq_lo` is high exactly when any of status bits 15..0 is set and bit 0 is set. `irq_hi` is high exactly when any of status bits 31..16 is set and bit 1 is set.
- R9: Unlisted offsets read as zero and ignore writes. A write to the input-level offset 0x20 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the synchronizer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Pad levels, asynchronous to `clk` |
| pin_out | output | 32 | Output data to the pads |
| pin_oe | output | 32 | Output enable per pin, 1 = driving |
| irq_lo | output | 1 | Lower-bank interrupt, pins 15..0 |
| irq_hi | output | 1 | Upper-bank interrupt, pins 31..16 |

## Verification
The properties assume that `bus_addr`, `bus_wr` and `bus_wdata` are stable around each rising clock edge, that only one register is written per cycle, and that `pin_in` may change at any time. The bench drives the bus and the pad levels only on falling clock edges, so every write lands on exactly one rising edge. It then waits out the two synchronizer stages before it judges edge capture. The same-cycle edge-and-clear case is lined up by counting those stages, so the clearing write meets the detected edge on the same rising edge.

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
  parameter int HALF        = 16,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       pin_in,
  output logic [31:0]       pin_out,
  output logic [31:0]       pin_oe,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam int W = 2 * HALF;

  localparam logic [ADDR_W-1:0] A_BANK   = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_DIR    = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_OSET   = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_OCLR   = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_LVL    = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_RSET   = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] A_RCLR   = ADDR_W'(8'h28);
  localparam logic [ADDR_W-1:0] A_FSET   = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] A_FCLR   = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(8'h34);

  logic [W-1:0] dir_q, out_q, rise_q, fall_q, stat_q, prev_q;
  logic [1:0]   bank_en_q;
  logic [W-1:0] sync_q [SYNC_STAGES];
  logic [W-1:0] lvl, hit;

  assign lvl = sync_q[SYNC_STAGES-1];
  assign hit = (lvl & ~prev_q & rise_q) | (~lvl & prev_q & fall_q);

  function automatic logic wr_at(input logic [ADDR_W-1:0] a);
    return bus_wr && (bus_addr == a);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= pin_in[W-1:0];
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q     <= '1;
      out_q     <= '0;
      rise_q    <= '0;
      fall_q    <= '0;
      stat_q    <= '0;
      bank_en_q <= '0;
    end else begin
      if (wr_at(A_DIR))  dir_q <= bus_wdata[W-1:0];
      if (wr_at(A_OSET)) out_q <= out_q | bus_wdata[W-1:0];
      if (wr_at(A_OCLR)) out_q <= out_q & ~bus_wdata[W-1:0];
      if (wr_at(A_RSET)) rise_q <= rise_q | bus_wdata[W-1:0];
      if (wr_at(A_RCLR)) rise_q <= rise_q & ~bus_wdata[W-1:0];
      if (wr_at(A_FSET)) fall_q <= fall_q | bus_wdata[W-1:0];
      if (wr_at(A_FCLR)) fall_q <= fall_q & ~bus_wdata[W-1:0];
      if (wr_at(A_BANK)) bank_en_q <= bus_wdata[1:0];
      stat_q <= (stat_q & ~(wr_at(A_STAT) ? bus_wdata[W-1:0] : '0)) | hit;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_BANK:         bus_rdata = {30'd0, bank_en_q};
      A_DIR:          bus_rdata = dir_q;
      A_OSET, A_OCLR: bus_rdata = out_q;
      A_LVL:          bus_rdata = lvl;
      A_RSET, A_RCLR: bus_rdata = rise_q;
      A_FSET, A_FCLR: bus_rdata = fall_q;
      A_STAT:         bus_rdata = stat_q;
      default:        bus_rdata = '0;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;
  assign irq_lo  = bank_en_q[0] & (|stat_q[HALF-1:0]);
  assign irq_hi  = bank_en_q[1] & (|stat_q[W-1:HALF]);
endmodule

module gpio_edge_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [31:0] pin_out,
  input logic [31:0] pin_oe,
  input logic        irq_lo,
  input logic        irq_hi,
  input logic [31:0] stat_q,
  input logic [1:0]  bank_en_q
);
  logic mapped;
  assign mapped = bus_addr inside {8'h08, 8'h10, 8'h18, 8'h1C, 8'h20,
                                   8'h24, 8'h28, 8'h2C, 8'h30, 8'h34};

  a_r2_dir_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 8'h10) |-> (bus_rdata == ~pin_oe));

  a_r3_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h18) |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

  a_r3_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h1C) |=> ((pin_out & $past(bus_wdata)) == 32'd0));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && (bus_addr == 8'h18 || bus_addr == 8'h1C)) |=> $stable(pin_out));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 8'h34) |=> (($past(stat_q) & ~stat_q) == 32'd0));

  a_r8_lo_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> (bank_en_q[0] && stat_q[15:0] != 16'd0));

  a_r8_hi_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> (bank_en_q[1] && stat_q[31:16] != 16'd0));

  a_r9_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (bus_rdata == 32'd0));
endmodule

bind gpio_edge_bank gpio_edge_bank_chk u_chk (.*);

// File: tb/test_gpio_edge_bank.sv
module test_gpio_edge_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq_lo, irq_hi;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  gpio_edge_bank i_gpio_edge_bank (.*);

  // {write offset, write data, expected read-back at the same offset}
  localparam int NV = 10;
  localparam logic [71:0] VEC [NV] = '{
    {8'h10, 32'h0000_FFFF, 32'h0000_FFFF},  // R2 direction
    {8'h18, 32'h0000_00F0, 32'h0000_00F0},  // R3 set
    {8'h1C, 32'h0000_0030, 32'h0000_00C0},  // R3 clear
    {8'h18, 32'h8000_0000, 32'h8000_00C0},  // R3 set, others kept
    {8'h24, 32'h0001_0001, 32'h0001_0001},  // R5 rise set
    {8'h28, 32'h0000_0001, 32'h0001_0000},  // R5 rise clear
    {8'h2C, 32'h0000_0003, 32'h0000_0003},  // R5 fall set
    {8'h08, 32'hFFFF_FFFF, 32'h0000_0003},  // R8 bank enable, two bits
    {8'h40, 32'h1234_5678, 32'h0000_0000},  // R9 unmapped
    {8'h00, 32'hFFFF_FFFF, 32'h0000_0000}   // R9 unmapped
  };
  localparam string VREQ [NV] = '{"R2","R3","R3","R3","R5","R5","R5","R8","R9","R9"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    #(10 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    // R1 reset state
    rd_reg(8'h10, r); check("R1", r, 32'hFFFF_FFFF);
    check("R1", pin_oe, 32'h0);
    check("R1", pin_out, 32'h0);
    rd_reg(8'h34, r); check("R1", r, 32'h0);
    rd_reg(8'h24, r); check("R1", r, 32'h0);
    rd_reg(8'h2C, r); check("R1", r, 32'h0);
    rd_reg(8'h08, r); check("R1", r, 32'h0);
    check("R1", {30'd0, irq_hi, irq_lo}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      wr_reg(VEC[k][71:64], VEC[k][63:32]);
      rd_reg(VEC[k][71:64], r);
      check(VREQ[k], r, VEC[k][31:0]);
    end

    // R2 direction drives output enables, R3 pins follow output data
    check("R2", pin_oe, 32'hFFFF_0000);
    check("R3", pin_out, 32'h8000_00C0);
    wr_reg(8'h18, 32'h0); check("R3", pin_out, 32'h8000_00C0);
    wr_reg(8'h1C, 32'h0); check("R3", pin_out, 32'h8000_00C0);

    // R4 synchronizer latency, level read regardless of direction
    @(negedge clk); pin_in = 32'h5A00_A5A5;
    @(negedge clk); rd_reg(8'h20, r); check("R4", r, 32'h0);
    @(negedge clk); rd_reg(8'h20, r); check("R4", r, 32'h5A00_A5A5);
    wait_n(2);
    // pin 0 rose with only fall enabled there: R6 no capture
    rd_reg(8'h34, r); check("R6", r, 32'h0);

    // R9 write to level offset ignored
    wr_reg(8'h20, 32'hFFFF_FFFF);
    rd_reg(8'h20, r); check("R9", r, 32'h5A00_A5A5);

    // R6 rise on pin1 not enabled, fall on pin1 enabled, rise on pin16 enabled
    @(negedge clk); pin_in[1] = 1'b1;
    wait_n(4);
    rd_reg(8'h34, r); check("R6", r, 32'h0);
    @(negedge clk); pin_in[1] = 1'b0; pin_in[16] = 1'b1;
    wait_n(4);
    rd_reg(8'h34, r); check("R6", r, 32'h0001_0002);
    check("R8", {30'd0, irq_hi, irq_lo}, 32'h3);
    wr_reg(8'h08, 32'h1);
    check("R8", {30'd0, irq_hi, irq_lo}, 32'h1);
    wr_reg(8'h08, 32'h2);
    check("R8", {30'd0, irq_hi, irq_lo}, 32'h2);
    wr_reg(8'h08, 32'h0);
    check("R8", {30'd0, irq_hi, irq_lo}, 32'h0);

    // R7 write-one-to-clear
    wr_reg(8'h34, 32'h0000_0002);
    rd_reg(8'h34, r); check("R7", r, 32'h0001_0000);
    wr_reg(8'h34, 32'h0);
    rd_reg(8'h34, r); check("R7", r, 32'h0001_0000);
    wr_reg(8'h08, 32'h3);
    check("R8", {30'd0, irq_hi, irq_lo}, 32'h2);

    // R7 edge captured in the same cycle as the clearing write wins
    @(negedge clk); pin_in[1] = 1'b1;
    wait_n(4);
    @(negedge clk); pin_in[1] = 1'b0;
    @(negedge clk);
    wr_reg(8'h34, 32'h0000_0002);
    rd_reg(8'h34, r); check("R7", r, 32'h0001_0002);
    check("R8", {30'd0, irq_hi, irq_lo}, 32'h3);

    // R5 fall clear stops capture
    wr_reg(8'h30, 32'h0000_0003);
    rd_reg(8'h30, r); check("R5", r, 32'h0);
    wr_reg(8'h34, 32'hFFFF_FFFF);
    @(negedge clk); pin_in[1] = 1'b1;
    wait_n(4);
    @(negedge clk); pin_in[1] = 1'b0;
    wait_n(4);
    rd_reg(8'h34, r); check("R6", r, 32'h0);
    check("R8", {30'd0, irq_hi, irq_lo}, 32'h0);

    // R1 reset again mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1", pin_oe, 32'h0);
    check("R1", pin_out, 32'h0);
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule